// File: doc/BRIEF.md
# Deglitched Two-Wire Register Slave

This block is a two-wire serial slave that gives a bus master byte access to a small external register file. It has no clock of its own on the serial clock line. Both bus lines are sampled by a free-running reference clock and pass through a synchronizer. The serial clock then goes through a persistence filter: a level change is taken only after it has held for `FILT_CYC` reference cycles. Incoming bits are captured on the delayed, filtered rising edge. Short pulses on the clock line, such as ringing or crosstalk spikes, are therefore dropped before they can shift a bit.

A transaction opens with a start condition and a byte made of a 7-bit device address and a direction bit. The device address is compared with static address pins. A write carries a register pointer byte and then any number of data bytes. Each data byte goes out on a one-cycle write strobe, and the pointer then advances. A read, usually reached through a repeated start, returns bytes from the current pointer. The pointer advances after every byte, and the master's acknowledge decides whether another byte follows. The data pin is open drain: the block only asserts an output enable that pulls the line low.

Top module: `tw_reg_slave`

## Requirements
- R1: A change on the serial clock line that lasts fewer than `FILT_CYC` (default 3) reference cycles after synchronization is ignored: it neither shifts a bit nor ends a phase.
- R2: Each received bit is the filtered data level in the cycle in which the filtered serial clock rises. Bits arrive most significant first.
- R3: A data-line fall while the clock is high is a start. A data-line rise while the clock is high is a stop. A stop returns the block to idle with the data line released, from any state. A start in the middle of a byte abandons that byte and begins a new address phase.
- R4: When bits 7..1 of the first byte after a start equal `dev_addr_i`, the block pulls SDA low for the whole ninth clock of that byte. Bit 0 set to 1 means a read.
- R5: When the address does not match, the block never pulls SDA and never strobes the register port until the next start. The register pointer keeps its value.
- R6: In a write, the byte after the address is loaded into the register pointer and acknowledged. Each later byte gives one `reg_we_o` pulse with `reg_addr_o` at the pointer, is acknowledged, and then advances the pointer by one.
- R7: After an address byte with bit 0 = 1, the block sends `reg_rdata_i` for the pointer, most significant bit first, and then advances the pointer. A master acknowledge (SDA low on the ninth clock) fetches the next byte. A non-acknowledge returns the block to idle.
- R8: The SDA output enable changes only in the cycle after a filtered falling edge of the serial clock, or after a start or stop.
- R9: The register pointer keeps its value across stop conditions, so a read with no pointer byte continues from where the last transaction left off.
- R10: After reset, `sda_oe_o`, `reg_we_o` and `reg_re_o` are 0 and `reg_addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | When 1, pull SDA low |
| dev_addr_i | input | 7 | Device address the block answers to |
| reg_addr_o | output | REG_AW | Register pointer |
| reg_wdata_o | output | 8 | Write data for the register file |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_re_o | output | 1 | One-cycle pulse when a read byte is fetched |
| reg_rdata_i | input | 8 | Register file contents at `reg_addr_o` (combinational) |

## Verification
A multi-byte burst write followed by a repeated-start burst read with acknowledge and non-acknowledge tells whether the pointer moves once per byte in both directions, and whether the master's last-byte response ends the read. A read with no pointer byte, issued after a stop and after a transaction to a foreign address, shows whether the pointer survives both. A write whose bits carry 2-cycle spikes in both the high and the low phase of the clock separates a working filter from one that adds or drops bits. A stop in the middle of a byte and a start in the middle of a byte, each followed by an ordinary write, show whether partial bytes are discarded with no stray strobe.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned DEV_AW = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_REG,
    ST_WR,
    ST_ACK,
    ST_RD,
    ST_MACK
  } tw_state_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tw_deglitch.sv
module tw_deglitch #(
  parameter int unsigned FILT_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned CNT_W = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYC - 1);

  logic             lvl_q;
  logic [CNT_W-1:0] cnt_q;

  // accept a new level only after it has held FILT_CYC cycles in a row
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b1;
      cnt_q <= '0;
    end else if (d_i != lvl_q) begin
      if (cnt_q == CNT_LAST) begin
        lvl_q <= d_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign q_o = lvl_q;
endmodule

// File: rtl/tw_bus_events.sv
module tw_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign rise_o  = scl_i & ~scl_q;
  assign fall_o  = ~scl_i & scl_q;
  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/tw_link_fsm.sv
module tw_link_fsm
  import tw_pkg::*;
#(
  parameter int unsigned REG_AW = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sda_i,
  input  logic                rise_i,
  input  logic                fall_i,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic [DEV_AW-1:0]   dev_addr_i,
  input  logic [BYTE_W-1:0]   rdata_i,
  output logic [REG_AW-1:0]   addr_o,
  output logic [BYTE_W-1:0]   wdata_o,
  output logic                we_o,
  output logic                re_o,
  output logic                sda_oe_o,
  output tw_state_e           state_o
);
  localparam int unsigned BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

  tw_state_e          state_q, after_ack_q;
  logic [BYTE_W-1:0]  shift_q;
  logic [BIT_W-1:0]   bit_cnt_q;
  logic               ack_on_q;
  logic               mack_q;
  logic [REG_AW-1:0]  addr_q;
  logic [BYTE_W-1:0]  wdata_q;
  logic               we_q, re_q;
  logic [BYTE_W-1:0]  rx_byte;
  logic               dev_hit;

  assign rx_byte = {shift_q[BYTE_W-2:0], sda_i};
  assign dev_hit = (rx_byte[BYTE_W-1:1] == dev_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      after_ack_q <= ST_IDLE;
      shift_q     <= '0;
      bit_cnt_q   <= '0;
      ack_on_q    <= 1'b0;
      mack_q      <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      we_q        <= 1'b0;
      re_q        <= 1'b0;
    end else begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      if (we_q) addr_q <= addr_q + 1'b1;  // pointer moves after the strobe
      if (start_i) begin
        state_q   <= ST_DEV;
        bit_cnt_q <= '0;
        ack_on_q  <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        ack_on_q <= 1'b0;
      end else begin
        case (state_q)
          ST_DEV, ST_REG, ST_WR: begin
            if (rise_i) begin
              shift_q   <= rx_byte;
              bit_cnt_q <= bit_cnt_q + 1'b1;
              if (bit_cnt_q == BIT_LAST) begin
                state_q <= ST_ACK;
                case (state_q)
                  ST_DEV: begin
                    if (!dev_hit)       state_q     <= ST_IDLE;
                    else if (rx_byte[0]) after_ack_q <= ST_RD;
                    else                 after_ack_q <= ST_REG;
                  end
                  ST_REG: begin
                    addr_q      <= rx_byte[REG_AW-1:0];
                    after_ack_q <= ST_WR;
                  end
                  default: begin
                    wdata_q     <= rx_byte;
                    we_q        <= 1'b1;
                    after_ack_q <= ST_WR;
                  end
                endcase
              end
            end
          end
          ST_ACK: begin
            if (fall_i) begin
              if (!ack_on_q) begin
                ack_on_q <= 1'b1;
              end else begin
                ack_on_q  <= 1'b0;
                bit_cnt_q <= '0;
                state_q   <= after_ack_q;
                if (after_ack_q == ST_RD) begin
                  shift_q <= rdata_i;
                  re_q    <= 1'b1;
                end
              end
            end
          end
          ST_RD: begin
            if (fall_i) begin
              if (bit_cnt_q == BIT_LAST) begin
                state_q <= ST_MACK;
                addr_q  <= addr_q + 1'b1;
              end else begin
                shift_q   <= {shift_q[BYTE_W-2:0], 1'b0};
                bit_cnt_q <= bit_cnt_q + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (rise_i) begin
              mack_q <= ~sda_i;
            end else if (fall_i) begin
              bit_cnt_q <= '0;
              if (mack_q) begin
                shift_q <= rdata_i;
                re_q    <= 1'b1;
                state_q <= ST_RD;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = ((state_q == ST_RD) && !shift_q[BYTE_W-1]) ||
                    ((state_q == ST_ACK) && ack_on_q);
  assign addr_o   = addr_q;
  assign wdata_o  = wdata_q;
  assign we_o     = we_q;
  assign re_o     = re_q;
  assign state_o  = state_q;
endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave
  import tw_pkg::*;
#(
  parameter int unsigned REG_AW      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYC    = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe_o,
  input  logic [DEV_AW-1:0]   dev_addr_i,
  output logic [REG_AW-1:0]   reg_addr_o,
  output logic [BYTE_W-1:0]   reg_wdata_o,
  output logic                reg_we_o,
  output logic                reg_re_o,
  input  logic [BYTE_W-1:0]   reg_rdata_i
);
  logic      scl_sync, sda_sync;
  logic      scl_f, sda_f;
  logic      scl_rise, scl_fall, start_det, stop_det;
  tw_state_e link_state;

  tw_sync #(.STAGES(SYNC_STAGES)) i_scl_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i), .q_o(scl_sync));
  tw_sync #(.STAGES(SYNC_STAGES)) i_sda_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_sync));

  // same filter on both lines keeps their relative timing
  tw_deglitch #(.FILT_CYC(FILT_CYC)) i_scl_flt (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_sync), .q_o(scl_f));
  tw_deglitch #(.FILT_CYC(FILT_CYC)) i_sda_flt (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_sync), .q_o(sda_f));

  tw_bus_events i_events (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_f), .sda_i(sda_f),
    .rise_o(scl_rise), .fall_o(scl_fall), .start_o(start_det), .stop_o(stop_det));

  tw_link_fsm #(.REG_AW(REG_AW)) i_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .sda_i(sda_f),
    .rise_i(scl_rise), .fall_i(scl_fall), .start_i(start_det), .stop_i(stop_det),
    .dev_addr_i(dev_addr_i), .rdata_i(reg_rdata_i),
    .addr_o(reg_addr_o), .wdata_o(reg_wdata_o), .we_o(reg_we_o), .re_o(reg_re_o),
    .sda_oe_o(sda_oe_o), .state_o(link_state));
endmodule

// File: rtl/tw_reg_slave_chk.sv
module tw_reg_slave_chk
  import tw_pkg::*;
#(
  parameter int unsigned FILT_CYC = 3
) (
  input logic      clk_i,
  input logic      rst_ni,
  input logic      scl_sync,
  input logic      scl_f,
  input logic      scl_rise,
  input logic      scl_fall,
  input logic      start_det,
  input logic      stop_det,
  input tw_state_e link_state,
  input logic      sda_oe_o,
  input logic      reg_we_o,
  input logic      reg_re_o
);
  generate
    if (FILT_CYC >= 3) begin : g_flt3
      assert_scl_filter_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(scl_f) |-> ($past(scl_sync) == scl_f) && ($past(scl_sync, 2) == scl_f) &&
                            ($past(scl_sync, 3) == scl_f));
    end else begin : g_flt_short
      assert_scl_filter_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(scl_f) |-> ($past(scl_sync) == scl_f));
    end
  endgenerate

  assert_we_after_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> $past(scl_rise));

  assert_stop_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (!sda_oe_o && link_state == ST_IDLE));

  assert_we_in_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> ($past(link_state) == ST_WR));

  assert_re_enters_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |-> (link_state == ST_RD));

  assert_oe_at_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> $past(scl_fall || start_det || stop_det));

  assert_strobes_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));
endmodule

bind tw_reg_slave tw_reg_slave_chk #(.FILT_CYC(FILT_CYC)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_sync(scl_sync), .scl_f(scl_f),
  .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
  .link_state(link_state), .sda_oe_o(sda_oe_o), .reg_we_o(reg_we_o), .reg_re_o(reg_re_o));

// File: tb/test_tw_reg_slave.sv
module test_tw_reg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;
  localparam int H = 20;
  localparam logic [6:0] DEV = 7'h52;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_we, reg_re;
  logic       sda_line;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [15:0] wr_q [$];
  int errs = 0, checks = 0, bad_oe = 0, ptr = 0;
  bit done = 1'b0;
  logic prev_oe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  tw_reg_slave i_tw_reg_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .dev_addr_i(DEV), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_we_o(reg_we), .reg_re_o(reg_re), .reg_rdata_i(reg_rdata));

  // register file model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h3C;
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected writes as strobes appear (R6, R5, R3, R1)
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_oe != prev_oe && scl_m) bad_oe++;
      prev_oe <= sda_oe;
      if (reg_we) begin
        if (wr_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected write {addr,data}", {reg_addr, reg_wdata}, 0);
        end else begin
          logic [15:0] e;
          e = wr_q.pop_front();
          chk({reg_addr, reg_wdata} == e, "R6", "write {addr,data}", {reg_addr, reg_wdata}, e);
        end
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_wr(input logic [7:0] a, input logic [7:0] d);
    wr_q.push_back({a, d});
    exp_mem[a] = d;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_cyc(Q);
    scl_m = 1'b1; wait_cyc(Q);
    sda_m = 1'b0; wait_cyc(Q);
    scl_m = 1'b0; wait_cyc(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_cyc(Q);
    scl_m = 1'b1; wait_cyc(Q);
    sda_m = 1'b1; wait_cyc(Q);
  endtask

  task automatic send_bit(input logic b, input bit glitch);
    sda_m = b;
    if (glitch) begin
      wait_cyc(4); scl_m = 1'b1; wait_cyc(2); scl_m = 1'b0; wait_cyc(6);
    end else begin
      wait_cyc(Q);
    end
    scl_m = 1'b1;
    if (glitch) begin
      wait_cyc(8); scl_m = 1'b0; wait_cyc(2); scl_m = 1'b1; wait_cyc(10);
    end else begin
      wait_cyc(H);
    end
    scl_m = 1'b0; wait_cyc(Q);
  endtask

  task automatic read_bit(output logic b);
    sda_m = 1'b1; wait_cyc(Q);
    scl_m = 1'b1; wait_cyc(H/2);
    b = sda_line; wait_cyc(H/2);
    scl_m = 1'b0; wait_cyc(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, input bit glitch, output logic ack_n);
    for (int i = 7; i >= 0; i--) send_bit(v[i], glitch);
    read_bit(ack_n);
  endtask

  task automatic read_byte(input bit last, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) read_bit(v[i]);
    send_bit(last, 1'b0);
  endtask

  task automatic expect_rd(input bit last, input string req);
    logic [7:0] got, e;
    e = exp_mem[ptr[7:0]];
    read_byte(last, got);
    chk(got == e, req, "read byte", got, e);
    ptr = (ptr + 1) % 256;
  endtask

  task automatic tx_acked(input logic [7:0] v, input bit glitch, input string req);
    logic a;
    send_byte(v, glitch, a);
    chk(a == 1'b0, req, "ack bit", a, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i) ^ 8'h3C;
    wait_cyc(5);
    // R10 reset state
    chk(sda_oe == 1'b0, "R10", "sda_oe in reset", sda_oe, 0);
    chk(reg_we == 1'b0 && reg_re == 1'b0, "R10", "strobes in reset", {reg_we, reg_re}, 0);
    chk(reg_addr == 8'h00, "R10", "pointer in reset", reg_addr, 0);
    rst_n = 1'b1;
    wait_cyc(5);
    chk(sda_oe == 1'b0, "R10", "sda_oe after reset", sda_oe, 0);

    // R4 R6 burst write of three bytes from 0x10
    bus_start();
    tx_acked({DEV, 1'b0}, 1'b0, "R4");
    tx_acked(8'h10, 1'b0, "R6");
    push_wr(8'h10, 8'hA1); tx_acked(8'hA1, 1'b0, "R6");
    push_wr(8'h11, 8'hB2); tx_acked(8'hB2, 1'b0, "R6");
    push_wr(8'h12, 8'hC3); tx_acked(8'hC3, 1'b0, "R6");
    bus_stop();
    chk(reg_addr == 8'h13, "R6", "pointer after burst write", reg_addr, 8'h13);

    // R7 pointer set, repeated start, burst read with final NACK
    bus_start();
    tx_acked({DEV, 1'b0}, 1'b0, "R4");
    tx_acked(8'h10, 1'b0, "R6");
    ptr = 8'h10;
    bus_start();
    tx_acked({DEV, 1'b1}, 1'b0, "R7");
    expect_rd(1'b0, "R7");
    expect_rd(1'b0, "R7");
    expect_rd(1'b1, "R7");
    bus_stop();
    chk(reg_addr == 8'h13, "R7", "pointer after read", reg_addr, 8'h13);

    // R9 read without pointer byte continues at 0x13
    bus_start();
    tx_acked({DEV, 1'b1}, 1'b0, "R9");
    expect_rd(1'b1, "R9");
    bus_stop();

    // R5 foreign address: no ack, no writes, pointer kept
    begin
      logic a;
      bus_start();
      send_byte({DEV ^ 7'h01, 1'b0}, 1'b0, a);
      chk(a == 1'b1, "R5", "foreign address ack bit", a, 1);
      send_byte(8'h20, 1'b0, a);
      chk(a == 1'b1, "R5", "foreign data ack bit", a, 1);
      send_byte(8'h55, 1'b0, a);
      chk(a == 1'b1, "R5", "foreign data ack bit", a, 1);
      bus_stop();
    end
    bus_start();
    tx_acked({DEV, 1'b1}, 1'b0, "R5");
    expect_rd(1'b1, "R5");
    bus_stop();

    // R1 R2 write with 2-cycle spikes in every bit
    bus_start();
    tx_acked({DEV, 1'b0}, 1'b1, "R1");
    tx_acked(8'h40, 1'b1, "R1");
    push_wr(8'h40, 8'h96); tx_acked(8'h96, 1'b1, "R1");
    push_wr(8'h41, 8'h5B); tx_acked(8'h5B, 1'b1, "R2");
    bus_stop();
    bus_start();
    tx_acked({DEV, 1'b0}, 1'b0, "R1");
    tx_acked(8'h40, 1'b0, "R1");
    ptr = 8'h40;
    bus_start();
    tx_acked({DEV, 1'b1}, 1'b0, "R1");
    expect_rd(1'b0, "R1");
    expect_rd(1'b1, "R2");
    bus_stop();

    // R3 stop in the middle of a data byte: no write
    bus_start();
    tx_acked({DEV, 1'b0}, 1'b0, "R3");
    tx_acked(8'h50, 1'b0, "R3");
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
    bus_stop();
    chk(reg_addr == 8'h50, "R3", "pointer after stop mid-byte", reg_addr, 8'h50);

    // R3 start in the middle of a byte restarts the address phase
    bus_start();
    tx_acked({DEV, 1'b0}, 1'b0, "R3");
    tx_acked(8'h60, 1'b0, "R3");
    for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b0);
    bus_start();
    tx_acked({DEV, 1'b0}, 1'b0, "R3");
    tx_acked(8'h61, 1'b0, "R3");
    push_wr(8'h61, 8'h7E); tx_acked(8'h7E, 1'b0, "R3");
    bus_stop();
    bus_start();
    tx_acked({DEV, 1'b0}, 1'b0, "R3");
    tx_acked(8'h60, 1'b0, "R3");
    ptr = 8'h60;
    bus_start();
    tx_acked({DEV, 1'b1}, 1'b0, "R3");
    expect_rd(1'b0, "R3");
    expect_rd(1'b1, "R3");
    bus_stop();
    wait_cyc(20);

    chk(bad_oe == 0, "R8", "sda_oe changes while SCL high", bad_oe, 0);
    chk(wr_q.size() == 0, "R6", "expected writes left over", wr_q.size(), 0);
    chk(sda_oe == 1'b0, "R3", "sda_oe idle at end", sda_oe, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog R7: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule